// File: doc/BRIEF.md
# Program Row Staging Buffer

This block collects the words of one program-memory row before that row is programmed. Each single-word load carries a word address and a 24-bit data word. The low address bits choose one of the row's slots. The word is held in a staging latch and does not reach the memory array yet. Slots may be filled in any order and overwritten at will. A bit vector shows which slots hold loaded data.

A commit request names a target word address. The target row is that address divided by the row size. A small controller then copies every slot, one per cycle, into a plain behavioural memory array. A slot that was never loaded copies as all ones, which is the erased value, so a partly filled row leaves its untouched cells erased. After the last word, the controller empties the staging latches and returns to idle.

A load that arrives while a commit is running is dropped. It also sets an error flag that stays set until reset. The array has a combinational read port so that programmed contents can be checked.

The controller has three states:
- ST_IDLE accepts loads and commits. A commit request moves it to ST_PROG.
- ST_PROG writes slot k on its k-th cycle. After the final slot it moves to ST_CLEAR.
- ST_CLEAR empties the latches, pulses `done`, and returns to ST_IDLE.

Top module: `prog_row_stager`

## Requirements
- R1: After reset, `busy`, `done`, `load_err` and `slot_valid` are all 0, and every array word reads all ones (0xFFFFFF).
- R2: An accepted load writes its data into slot `ld_addr % 32` and sets `slot_valid` bit (`ld_addr % 32`). The upper address bits play no part in choosing the slot. The array contents do not change until a commit.
- R3: Slots may be loaded in any order. Loading the same slot again replaces its earlier data, and the commit writes only the latest value.
- R4: A commit accepted in ST_IDLE writes all 32 slots to array words `row*32 .. row*32+31`, where `row = commit_addr / 32`. Words of every other row keep their values.
- R5: Committing is allowed with any number of loaded slots, including none. Each slot not loaded since the previous commit is written as all ones.
- R6: `busy` rises in the cycle after a commit is accepted and stays high for exactly 33 cycles (32 in ST_PROG, 1 in ST_CLEAR). `done` is high for exactly one cycle, the last cycle of `busy`.
- R7: When a commit completes, `slot_valid` returns to 0 and every slot returns to all ones.
- R8: A load is ignored if `busy` is high or if it arrives in the same cycle as an accepted commit. Such a load changes no slot and no valid bit, and it sets `load_err`. `load_err` stays set until reset.
- R9: A commit request made while `busy` is high is ignored. It starts no further operation and writes no row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Single-word load strobe |
| ld_addr | input | ADDR_W (8) | Word address of the load; the low 5 bits select the slot |
| ld_data | input | WORD_W (24) | Word to stage |
| commit_req | input | 1 | Request to program the staged row |
| commit_addr | input | ADDR_W (8) | Word address whose row is programmed |
| busy | output | 1 | Commit in progress |
| done | output | 1 | One-cycle pulse in the final commit cycle |
| load_err | output | 1 | Sticky flag for a rejected load |
| slot_valid | output | SLOTS (32) | Slots loaded since the last commit |
| rd_addr | input | ADDR_W (8) | Array read address |
| rd_data | output | WORD_W (24) | Array word at `rd_addr` |

## Verification
A slot-index fault shows up on `slot_valid` in the cycle after the load, so the R2 checks catch it immediately. A staging-latch fault cannot be seen until a commit; it then appears as wrong data in the target row of the array. A controller fault (wrong count, wrong row, missing clear) shows as a `busy` width other than 33, as writes landing in the wrong row, or as a stale slot surviving into the next commit. A later empty commit to the same row exposes that last case.

// File: rtl/stager_pkg.sv
package stager_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_CLEAR = 2'd2
    } stager_state_e;

endpackage

// File: rtl/stager_latches.sv
module stager_latches #(
    parameter int WORD_W = 24,
    parameter int SLOTS  = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              clr,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [WORD_W-1:0] rd_data,
    output logic [SLOTS-1:0]  valid
);

    logic [WORD_W-1:0] hold [SLOTS];

    // One register and one valid flag per slot.
    // Clear has priority over a write to the same slot.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold[s]  <= '1;
                valid[s] <= 1'b0;
            end else if (clr) begin
                hold[s]  <= '1;
                valid[s] <= 1'b0;
            end else if (wr_en && (wr_slot == SLOT_W'(s))) begin
                hold[s]  <= wr_data;
                valid[s] <= 1'b1;
            end
        end
    end

    assign rd_data = hold[rd_slot];

endmodule

// File: rtl/stager_array.sv
module stager_array #(
    parameter int WORD_W = 24,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] cells [DEPTH];

    // Every cell starts erased (all ones).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/stager_ctrl.sv
module stager_ctrl
    import stager_pkg::*;
#(
    parameter int SLOTS = 32,
    parameter int ROWS  = 8,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int ROW_W  = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic              commit_req,
    input  logic [ROW_W-1:0]  commit_row,
    output logic              load_ok,
    output logic              prog_we,
    output logic [SLOT_W-1:0] prog_slot,
    output logic [ROW_W-1:0]  prog_row,
    output logic              clr,
    output logic              busy,
    output logic              done,
    output logic              load_err
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    stager_state_e     state_q, state_d;
    logic [SLOT_W-1:0] cnt_q;
    logic [ROW_W-1:0]  row_q;
    logic              err_q;
    logic              accept;

    // A commit is accepted only in ST_IDLE; a load in that same cycle is rejected.
    assign accept  = (state_q == ST_IDLE) && commit_req;
    assign load_ok = ld_valid && (state_q == ST_IDLE) && !commit_req;

    // State register, slot counter, captured row and sticky error flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            row_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                row_q <= commit_row;
                cnt_q <= '0;
            end else if (state_q == ST_PROG) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (ld_valid && !load_ok) begin
                err_q <= 1'b1;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (commit_req)           state_d = ST_PROG;
            ST_PROG:  if (cnt_q == LAST_SLOT)   state_d = ST_CLEAR;
            ST_CLEAR:                           state_d = ST_IDLE;
            default:                            state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        prog_we  = 1'b0;
        clr      = 1'b0;
        done     = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_PROG:  begin
                prog_we = 1'b1;
                busy    = 1'b1;
            end
            ST_CLEAR: begin
                clr  = 1'b1;
                done = 1'b1;
                busy = 1'b1;
            end
            default:  ;
        endcase
    end

    assign prog_slot = cnt_q;
    assign prog_row  = row_q;
    assign load_err  = err_q;

endmodule

// File: rtl/prog_row_stager.sv
module prog_row_stager #(
    parameter int WORD_W = 24,
    parameter int SLOTS  = 32,
    parameter int ROWS   = 8,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int ADDR_W = SLOT_W + ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              commit_req,
    input  logic [ADDR_W-1:0] commit_addr,
    output logic              busy,
    output logic              done,
    output logic              load_err,
    output logic [SLOTS-1:0]  slot_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic              load_ok;
    logic              prog_we;
    logic [SLOT_W-1:0] prog_slot;
    logic [ROW_W-1:0]  prog_row;
    logic              clr;
    logic [WORD_W-1:0] staged_word;
    logic              unused_addr_bits;

    // Row bits of a load and slot bits of a commit address take no part.
    assign unused_addr_bits = ^{ld_addr[ADDR_W-1:SLOT_W], commit_addr[SLOT_W-1:0]};

    stager_ctrl #(.SLOTS(SLOTS), .ROWS(ROWS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_valid   (ld_valid),
        .commit_req (commit_req),
        .commit_row (commit_addr[ADDR_W-1:SLOT_W]),
        .load_ok    (load_ok),
        .prog_we    (prog_we),
        .prog_slot  (prog_slot),
        .prog_row   (prog_row),
        .clr        (clr),
        .busy       (busy),
        .done       (done),
        .load_err   (load_err)
    );

    stager_latches #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_latches (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (load_ok),
        .wr_slot (ld_addr[SLOT_W-1:0]),
        .wr_data (ld_data),
        .clr     (clr),
        .rd_slot (prog_slot),
        .rd_data (staged_word),
        .valid   (slot_valid)
    );

    stager_array #(.WORD_W(WORD_W), .DEPTH(ROWS * SLOTS)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (prog_we),
        .waddr ({prog_row, prog_slot}),
        .wdata (staged_word),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/stager_chk.sv
module stager_chk #(
    parameter int SLOTS  = 32,
    parameter int ADDR_W = 8,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_valid,
    input logic [ADDR_W-1:0] ld_addr,
    input logic              commit_req,
    input logic              busy,
    input logic              done,
    input logic              load_err,
    input logic [SLOTS-1:0]  slot_valid
);

    // R6
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && !busy) |=> busy);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R7
    valid_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (slot_valid == '0));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |=> load_err);

    // R8
    reject_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && (busy || commit_req)) |=> load_err);

    // R2
    load_marks_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !busy && !commit_req) |=> slot_valid[$past(ld_addr[SLOT_W-1:0])]);

    // R8
    busy_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(slot_valid));

endmodule

bind prog_row_stager stager_chk #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_valid   (ld_valid),
    .ld_addr    (ld_addr),
    .commit_req (commit_req),
    .busy       (busy),
    .done       (done),
    .load_err   (load_err),
    .slot_valid (slot_valid)
);

// File: tb/prog_row_stager_tb.sv
module prog_row_stager_tb;

    localparam int W     = 24;
    localparam int NS    = 32;
    localparam int NR    = 8;
    localparam int DEPTH = NS * NR;
    localparam logic [W-1:0] ONES = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_valid = 1'b0;
    logic [7:0]    ld_addr = '0;
    logic [W-1:0]  ld_data = '0;
    logic          commit_req = 1'b0;
    logic [7:0]    commit_addr = '0;
    logic          busy, done, load_err;
    logic [NS-1:0] slot_valid;
    logic [7:0]    rd_addr = '0;
    logic [W-1:0]  rd_data;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [W-1:0]  exp_mem [DEPTH];
    logic [W-1:0]  stage   [NS];
    logic [NS-1:0] exp_valid;

    always #4 clk = ~clk;

    prog_row_stager u_dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_data(ld_data), .commit_req(commit_req), .commit_addr(commit_addr),
        .busy(busy), .done(done), .load_err(load_err), .slot_valid(slot_valid),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = ONES;
        for (int s = 0; s < NS; s++) stage[s] = ONES;
        exp_valid = '0;
    endtask

    task automatic check_array(input string req);
        int bad = -1;
        logic [W-1:0] badv = '0;
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = 8'(a);
            #1;
            if (rd_data !== exp_mem[a] && bad < 0) begin
                bad = a;
                badv = rd_data;
            end
        end
        tests++;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s: array[%0d] actual 0x%0h expected 0x%0h",
                     req, bad, badv, exp_mem[bad]);
        end
    endtask

    task automatic load(input int addr, input logic [W-1:0] data);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_addr  = 8'(addr);
        ld_data  = data;
        @(negedge clk);
        ld_valid = 1'b0;
        stage[addr % NS] = data;
        exp_valid[addr % NS] = 1'b1;
    endtask

    task automatic do_commit(input int row, input int off, input bit same_load,
                             input bit mid_load, input bit mid_commit);
        int bcnt = 0;
        int dcnt = 0;
        @(negedge clk);
        commit_req  = 1'b1;
        commit_addr = 8'(row * NS + off);
        if (same_load) begin
            ld_valid = 1'b1;
            ld_addr  = 8'd9;
            ld_data  = 24'h000000;
        end
        @(negedge clk);
        commit_req = 1'b0;
        ld_valid   = 1'b0;
        while (busy && bcnt < 100) begin
            bcnt++;
            if (done) dcnt++;
            if (mid_load && bcnt == 3) begin
                ld_valid = 1'b1;
                ld_addr  = 8'd5;
                ld_data  = 24'h000000;
            end
            if (mid_commit && bcnt == 5) begin
                commit_req  = 1'b1;
                commit_addr = 8'(6 * NS);
            end
            @(negedge clk);
            ld_valid   = 1'b0;
            commit_req = 1'b0;
        end
        // R6: busy width and done pulse count
        check("R6 busy cycles", 32'(bcnt), 32'd33);
        check("R6 done pulses", 32'(dcnt), 32'd1);
        for (int s = 0; s < NS; s++) begin
            exp_mem[row * NS + s] = stage[s];
            stage[s] = ONES;
        end
        exp_valid = '0;
        // R7: valid bits cleared
        check("R7 slot_valid after commit", slot_valid, 32'h0);
    endtask

    task automatic t_reset();
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        check("R1 load_err", 32'(load_err), 32'd0);
        check("R1 slot_valid", slot_valid, 32'h0);
        check_array("R1 erased array");
    endtask

    task automatic t_stage_only();
        load(5 * NS + 7, 24'h123456);
        check("R2 valid after first load", slot_valid, exp_valid);
        load(3, 24'hABCDEF);
        check("R2 valid after second load", slot_valid, exp_valid);
        check_array("R2 array untouched before commit");
        do_commit(2, 9, 1'b0, 1'b0, 1'b0);
        check_array("R4 row from commit address");
    endtask

    task automatic t_order_overwrite();
        load(20, 24'h000014);
        load(2,  24'h111111);
        load(31, 24'h00001F);
        load(0,  24'h000100);
        load(2,  24'h222222);
        check("R3 valid bits", slot_valid, exp_valid);
        do_commit(1, 0, 1'b0, 1'b0, 1'b0);
        check_array("R3 latest write wins");
    endtask

    task automatic t_full_then_partial();
        for (int s = NS - 1; s >= 0; s--) load(s, 24'(32'h00A000 + s));
        check("R4 all valid", slot_valid, 32'hFFFF_FFFF);
        do_commit(3, 31, 1'b0, 1'b0, 1'b0);
        check_array("R4 full row");
        load(10, 24'h5A5A5A);
        do_commit(3, 4, 1'b0, 1'b0, 1'b0);
        check_array("R5 unloaded slots erased");
        do_commit(1, 0, 1'b0, 1'b0, 1'b0);
        check_array("R5 empty commit / R7 latches reset");
    endtask

    task automatic t_reject();
        load(5, 24'h0F0F0F);
        do_commit(4, 0, 1'b0, 1'b1, 1'b1);
        check("R8 load_err after busy load", 32'(load_err), 32'd1);
        check_array("R8 busy load ignored, R9 extra commit ignored");
        do_commit(4, 0, 1'b1, 1'b0, 1'b0);
        check_array("R8 same-cycle load ignored");
        load(12, 24'h777777);
        check("R8 load_err sticky", 32'(load_err), 32'd1);
        check("R8 valid after good load", slot_valid, exp_valid);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check("R1 load_err cleared by reset", 32'(load_err), 32'd0);
        check("R1 valid cleared by reset", slot_valid, 32'h0);
        check_array("R1 array erased by reset");
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stage_only();
        t_order_overwrite();
        t_full_then_partial();
        t_reject();
        t_reset_again();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule